// File: doc/BRIEF.md
# Edge-Triggered GPIO Interrupt Aggregator

This block collects a set of general-purpose input interrupt lines (76 by default) and merges them into one interrupt request for a parent interrupt controller. Each line is first brought into the local clock domain by a two-flop synchronizer. An edge detector then watches for the polarity chosen for that line, either rising or falling. A detected edge sets a sticky pending flag. The flag stays set until software clears it with a write-one-to-clear acknowledge. A per-line mask bit decides whether a pending line contributes to the merged output.

Software uses a small register port with byte addresses, 16-bit data, separate read and write strobes, and registered read data. The lines are spread over four banks: mask, acknowledge, polarity and status. Line n always lives in register n/16 of a bank, at bit n mod 16. The registers of a bank are spaced 4 bytes apart. Once the interrupt handler sees the merged output, it scans the status bank, services each set bit, and acknowledges it.

Top module: `gpio_irq_aggregator`

## Requirements
- R1: After reset every mask bit is 1, so all lines are masked. Every polarity bit is 0, every pending flag is clear, and irq_out is 0. Mask registers 0 to 3 read 0xFFFF and mask register 4 reads 0x0FFF.
- R2: Line n is mapped to register n/16 at bit n mod 16, and consecutive registers of a bank are 4 bytes apart. The bank base addresses are: mask 0x00, acknowledge 0x28, polarity 0x40, status 0xC0.
- R3: With polarity bit 0, a rising edge on an input sets that line's pending flag. The flag becomes visible in status and irq_out after the third rising clock edge following the input change, and is not yet visible after the second.
- R4: With polarity bit 1, a falling edge on an input sets that line's pending flag, with the same latency as R3.
- R5: An edge of the polarity that is not selected leaves the pending flag unchanged.
- R6: An edge on a masked line still sets its pending flag. A status bit reads as pending AND NOT mask, so clearing the mask later shows the stored event.
- R7: Writing 1 to a bit of the acknowledge bank clears that line's pending flag. Writing 0 leaves the flag as it was.
- R8: If a detected edge and an acknowledge for the same line occur in the same clock cycle, the edge wins and the pending flag stays set.
- R9: irq_out is the OR over all lines of pending AND NOT mask. It stays 1 while any unmasked line is pending.
- R10: The following read as 0, and writes to them are ignored:
  - bits 12 to 15 of register 4 in the mask and polarity banks;
  - the acknowledge bank, which is write-only;
  - the status bank, which is read-only;
  - addresses that decode to no register.
- R11: reg_rdata is loaded from the addressed register on a clock edge where reg_rd is 1, and keeps its value on edges where reg_rd is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 76 | Raw interrupt inputs, asynchronous to clk |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 16 | Write data |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | 16 | Registered read data |
| irq_out | output | 1 | Merged interrupt to the parent controller |

## Verification
Single lines are driven through both edge directions under both polarity settings. This separates a correct edge selector from one that ignores the polarity bit or reacts to both edges. The lines used are 5, 16, 37, 70 and 75, which touch the first, a middle and the last register of each bank. This catches a wrong index or bit position, including at the reserved tail of register 4.

A masked edge followed by an unmask shows that the event was latched rather than dropped. Acknowledging one of two pending lines shows that the merged output follows the remaining line. Finally, an acknowledge is timed into the exact cycle in which a new edge is detected. This separates the edge-wins rule from an acknowledge-wins variant.

// File: rtl/gpi_pkg.sv
package gpi_pkg;
    // Bank base byte addresses; software relies on these.
    localparam int unsigned BASE_MASK = 32'h00;
    localparam int unsigned BASE_ACK  = 32'h28;
    localparam int unsigned BASE_TYPE = 32'h40;
    localparam int unsigned BASE_STAT = 32'hC0;
    localparam int unsigned REG_STEP  = 4;

    typedef enum logic [2:0] {
        BK_NONE,
        BK_MASK,
        BK_ACK,
        BK_TYPE,
        BK_STAT
    } bank_e;

    function automatic bit bank_hit(input int unsigned a,
                                    input int unsigned base,
                                    input int unsigned nregs);
        return (a >= base) && (a < base + REG_STEP * nregs) && ((a % REG_STEP) == 0);
    endfunction
endpackage

// File: rtl/gpi_sync.sv
module gpi_sync #(
    parameter int W      = 76,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpi_line.sv
module gpi_line (
    input  logic clk,
    input  logic rst_n,
    input  logic level,       // synchronized input
    input  logic fall_sel,    // 1: falling edge, 0: rising edge
    input  logic ack,         // write-one-to-clear pulse
    output logic edge_hit,
    output logic pend
);
    logic prev_q;

    always_comb begin
        if (fall_sel) edge_hit = prev_q & ~level;
        else          edge_hit = ~prev_q & level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            pend   <= 1'b0;
        end else begin
            prev_q <= level;
            if (edge_hit)  pend <= 1'b1;   // a new edge beats a clear
            else if (ack)  pend <= 1'b0;
        end
    end
endmodule

// File: rtl/gpi_regs.sv
module gpi_regs
    import gpi_pkg::*;
#(
    parameter int NUM_LINES = 76,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 wr,
    input  logic [DATA_W-1:0]    wdata,
    input  logic                 rd,
    output logic [DATA_W-1:0]    rdata,
    input  logic [NUM_LINES-1:0] pend,
    output logic [NUM_LINES-1:0] mask_o,
    output logic [NUM_LINES-1:0] type_o,
    output logic [NUM_LINES-1:0] ack_o
);
    localparam int NUM_REGS = (NUM_LINES + DATA_W - 1) / DATA_W;
    localparam int PAD      = NUM_REGS * DATA_W;

    function automatic logic [PAD-1:0] live_bits();
        logic [PAD-1:0] v;
        for (int i = 0; i < PAD; i++) v[i] = (i < NUM_LINES);
        return v;
    endfunction

    localparam logic [PAD-1:0] LIVE = live_bits();

    logic [PAD-1:0] mask_q, type_q, stat_v;
    bank_e          bank;
    int unsigned    a_int, idx;

    always_comb begin
        a_int = int'(addr);
        bank  = BK_NONE;
        idx   = 0;
        if (bank_hit(a_int, BASE_MASK, NUM_REGS)) begin
            bank = BK_MASK; idx = (a_int - BASE_MASK) / REG_STEP;
        end else if (bank_hit(a_int, BASE_ACK, NUM_REGS)) begin
            bank = BK_ACK;  idx = (a_int - BASE_ACK) / REG_STEP;
        end else if (bank_hit(a_int, BASE_TYPE, NUM_REGS)) begin
            bank = BK_TYPE; idx = (a_int - BASE_TYPE) / REG_STEP;
        end else if (bank_hit(a_int, BASE_STAT, NUM_REGS)) begin
            bank = BK_STAT; idx = (a_int - BASE_STAT) / REG_STEP;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= LIVE;
            type_q <= '0;
        end else if (wr) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (idx == r && bank == BK_MASK)
                    mask_q[r*DATA_W +: DATA_W] <= wdata & LIVE[r*DATA_W +: DATA_W];
                if (idx == r && bank == BK_TYPE)
                    type_q[r*DATA_W +: DATA_W] <= wdata & LIVE[r*DATA_W +: DATA_W];
            end
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_LINES; gi++) begin : g_ack
            assign ack_o[gi] = wr && (bank == BK_ACK) && (idx == gi / DATA_W)
                               && wdata[gi % DATA_W];
        end
    endgenerate

    always_comb begin
        stat_v = '0;
        stat_v[NUM_LINES-1:0] = pend & ~mask_q[NUM_LINES-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd) begin
            unique case (bank)
                BK_MASK: rdata <= mask_q[idx*DATA_W +: DATA_W];
                BK_TYPE: rdata <= type_q[idx*DATA_W +: DATA_W];
                BK_STAT: rdata <= stat_v[idx*DATA_W +: DATA_W];
                BK_ACK:  rdata <= '0;
                BK_NONE: rdata <= '0;
                default: rdata <= '0;
            endcase
        end
    end

    assign mask_o = mask_q[NUM_LINES-1:0];
    assign type_o = type_q[NUM_LINES-1:0];
endmodule

// File: rtl/gpio_irq_aggregator.sv
module gpio_irq_aggregator #(
    parameter int NUM_LINES   = 76,
    parameter int DATA_W      = 16,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic                 reg_rd,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq_out
);
    logic [NUM_LINES-1:0] lvl, pend, edge_hit, ack_hit, mask_v, type_v;

    gpi_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_in),
        .q     (lvl)
    );

    genvar li;
    generate
        for (li = 0; li < NUM_LINES; li++) begin : g_line
            gpi_line u_line (
                .clk      (clk),
                .rst_n    (rst_n),
                .level    (lvl[li]),
                .fall_sel (type_v[li]),
                .ack      (ack_hit[li]),
                .edge_hit (edge_hit[li]),
                .pend     (pend[li])
            );
        end
    endgenerate

    gpi_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .addr   (reg_addr),
        .wr     (reg_wr),
        .wdata  (reg_wdata),
        .rd     (reg_rd),
        .rdata  (reg_rdata),
        .pend   (pend),
        .mask_o (mask_v),
        .type_o (type_v),
        .ack_o  (ack_hit)
    );

    assign irq_out = |(pend & ~mask_v);
endmodule

// File: rtl/gpi_checker.sv
module gpi_checker #(
    parameter int NUM_LINES = 76
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] pend,
    input logic [NUM_LINES-1:0] edge_hit,
    input logic [NUM_LINES-1:0] ack,
    input logic [NUM_LINES-1:0] mask,
    input logic                 irq_out
);
    AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (&mask) |-> !irq_out);  // R9

    AST_RESET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (&mask)); // R1

    genvar k;
    generate
        for (k = 0; k < NUM_LINES; k++) begin : g_chk
            AST_SET_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(pend[k]) |-> $past(edge_hit[k]));  // R5

            AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
                $past(edge_hit[k]) |-> pend[k]);  // R8

            AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                $past(ack[k] && !edge_hit[k]) |-> !pend[k]);  // R7

            AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
                $past(pend[k] && !ack[k]) |-> pend[k]);  // R6
        end
    endgenerate
endmodule

bind gpio_irq_aggregator gpi_checker #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pend     (pend),
    .edge_hit (edge_hit),
    .ack      (ack_hit),
    .mask     (mask_v),
    .irq_out  (irq_out)
);

// File: tb/gpio_irq_aggregator_tb.sv
`timescale 1ns/1ps
module gpio_irq_aggregator_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [75:0] irq_in = '0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        reg_rd = 1'b0;
    logic [15:0] reg_rdata;
    logic        irq_out;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    gpio_irq_aggregator u_dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rd(reg_rd),
        .reg_rdata(reg_rdata), .irq_out(irq_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // All tasks start and end just after a falling clock edge.
    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc(1);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        reg_addr = a; reg_rd = 1'b1;
        cyc(1);
        reg_rd = 1'b0;
        d = reg_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        check(irq_out == 1'b0, "R1 irq_out", irq_out, 0);
        for (int r = 0; r < 5; r++) begin
            rd(8'(r * 4), v);
            check(v == ((r == 4) ? 16'h0FFF : 16'hFFFF), "R1 mask reset", v, (r == 4) ? 16'h0FFF : 16'hFFFF);
            rd(8'(8'h40 + r * 4), v);
            check(v == 16'h0, "R1 type reset", v, 0);
            rd(8'(8'hC0 + r * 4), v);
            check(v == 16'h0, "R1 status reset", v, 0);
        end
    endtask

    task automatic t_rising();
        logic [15:0] v;
        for (int r = 0; r < 5; r++) wr(8'(r * 4), 16'h0000);
        irq_in[5] = 1'b1;
        cyc(2);
        check(irq_out == 1'b0, "R3 not before third edge", irq_out, 0);
        cyc(1);
        check(irq_out == 1'b1, "R3 irq after third edge", irq_out, 1);
        rd(8'hC0, v);
        check(v == 16'h0020, "R2 R3 status line 5", v, 16'h0020);
        wr(8'h28, 16'h0000);
        rd(8'hC0, v);
        check(v == 16'h0020, "R7 ack zero no effect", v, 16'h0020);
        wr(8'h28, 16'h0020);
        rd(8'hC0, v);
        check(v == 16'h0000, "R7 ack one clears", v, 0);
        irq_in[5] = 1'b0;
        cyc(4);
        rd(8'hC0, v);
        check(v == 16'h0000 && !irq_out, "R5 falling ignored in rising mode", v, 0);
    endtask

    task automatic t_falling();
        logic [15:0] v;
        wr(8'h48, 16'h0020);
        rd(8'h48, v);
        check(v == 16'h0020, "R2 type reg 2 readback", v, 16'h0020);
        irq_in[37] = 1'b1;
        cyc(4);
        rd(8'hC8, v);
        check(v == 16'h0000, "R5 rising ignored in falling mode", v, 0);
        irq_in[37] = 1'b0;
        cyc(3);
        check(irq_out == 1'b1, "R4 falling edge irq", irq_out, 1);
        rd(8'hC8, v);
        check(v == 16'h0020, "R4 status line 37", v, 16'h0020);
        wr(8'h30, 16'h0020);
        wr(8'h48, 16'h0000);
        check(irq_out == 1'b0, "R7 ack line 37", irq_out, 0);
    endtask

    task automatic t_mask();
        logic [15:0] v;
        wr(8'h10, 16'h0800);
        irq_in[75] = 1'b1;
        cyc(4);
        rd(8'hD0, v);
        check(v == 16'h0000, "R6 masked status hidden", v, 0);
        check(irq_out == 1'b0, "R9 masked no irq", irq_out, 0);
        wr(8'h10, 16'h0000);
        rd(8'hD0, v);
        check(v == 16'h0800, "R6 latched while masked", v, 16'h0800);
        check(irq_out == 1'b1, "R9 unmasked irq", irq_out, 1);
        wr(8'h38, 16'h0800);
        irq_in[75] = 1'b0;
        cyc(3);
    endtask

    task automatic t_race();
        logic [15:0] v;
        irq_in[16] = 1'b1;
        cyc(4);
        irq_in[16] = 1'b0;
        cyc(4);
        rd(8'hC4, v);
        check(v == 16'h0001, "R8 pending before race", v, 16'h0001);
        irq_in[16] = 1'b1;
        cyc(2);                 // edge detected during the next cycle
        wr(8'h2C, 16'h0001);    // acknowledge lands on the same edge
        rd(8'hC4, v);
        check(v == 16'h0001, "R8 edge wins over ack", v, 16'h0001);
        wr(8'h2C, 16'h0001);
        rd(8'hC4, v);
        check(v == 16'h0000, "R7 plain ack after race", v, 0);
        irq_in[16] = 1'b0;
        cyc(3);
    endtask

    task automatic t_multi();
        irq_in[0] = 1'b1; irq_in[70] = 1'b1;
        cyc(3);
        check(irq_out == 1'b1, "R9 two pending", irq_out, 1);
        wr(8'h28, 16'h0001);
        check(irq_out == 1'b1, "R9 one still pending", irq_out, 1);
        wr(8'h38, 16'h0040);
        check(irq_out == 1'b0, "R9 all cleared", irq_out, 0);
        irq_in[0] = 1'b0; irq_in[70] = 1'b0;
        cyc(3);
    endtask

    task automatic t_reserved();
        logic [15:0] v;
        wr(8'h50, 16'hFFFF);
        rd(8'h50, v);
        check(v == 16'h0FFF, "R10 reserved type bits", v, 16'h0FFF);
        wr(8'h50, 16'h0000);
        wr(8'h10, 16'hF000);
        rd(8'h10, v);
        check(v == 16'h0000, "R10 reserved mask bits", v, 0);
        rd(8'h28, v);
        check(v == 16'h0000, "R10 ack reads zero", v, 0);
        wr(8'hC0, 16'hFFFF);
        rd(8'hC0, v);
        check(v == 16'h0000 && !irq_out, "R10 status write ignored", v, 0);
        rd(8'h14, v);
        check(v == 16'h0000, "R10 unmapped reads zero", v, 0);
        rd(8'h40, v);
        wr(8'h40, 16'h1234);
        check(reg_rdata == 16'h0000, "R11 rdata holds without read", reg_rdata, 0);
        rd(8'h40, v);
        check(v == 16'h1234, "R11 read after write", v, 16'h1234);
        wr(8'h40, 16'h0000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(2);
        t_reset();
        t_rising();
        t_falling();
        t_mask();
        t_race();
        t_multi();
        t_reserved();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule